// File: doc/BRIEF.md
# Phase-Offset DDS Phase Generator

This block is the digital front end of a direct digital synthesizer. A 32-bit accumulator adds a frequency tuning word on every reference clock, so the output frequency is the tuning word times the clock frequency divided by 2^32. A 5-bit offset is then added to the top of the phase. Its bits are weighted 180°, 90°, 45°, 22.5° and 11.25°, and any combination may be set. The upper 12 bits of the offset phase leave the block as an address for an external amplitude lookup. The top bit of the same sum also leaves as a registered square wave.

New words are captured on an update strobe and travel through fixed delay lines. A new tuning word reaches the output 18 clocks after the strobe. A new offset reaches it 13 clocks after the strobe. Strobes may come on consecutive cycles, and each one matures in turn. A power-down input freezes the accumulator and holds the outputs at zero. A synchronous reset clears everything. For clean clock generation the tuning word should stay below about a third of 2^32. Words up to half of 2^32 remain usable.

Top module: `dds_phase_core`

## Requirements
- R1: On every clock edge with `rst` and `pwr_dn` low, the internal 32-bit phase grows by the active tuning word, modulo 2^32. Both active words are zero after reset.
- R2: `phase_addr` equals bits [31:20] of (phase + offset × 2^27), where `pofs_in[4]` weighs 180°, bit 3 weighs 90°, and so on down to bit 0 at 11.25°.
- R3: If `upd` is sampled high at edge s, the output after edge s+18 is the first whose phase includes an increment made with the new tuning word (the word is active from edge s+16 on).
- R4: If `upd` is sampled high at edge s, the output after edge s+13 is the first computed with the new offset word.
- R5: Strobes on consecutive or closely spaced cycles are all kept. Each word takes effect in strobe order at its own latency, and none overwrites another.
- R6: While `pwr_dn` is sampled high, `phase_addr` and `sq_out` are zero on the following cycle and the phase holds. After release, the next output is formed from the held phase.
- R7: With `rst` sampled high, the outputs are zero on the next cycle. The phase, both active words and every update still in flight are discarded.
- R8: `sq_out` always equals bit 11 of `phase_addr`, the MSB of the offset phase, from the same register stage.
- R9: Changes on `ftw_in` and `pofs_in` while `upd` is low have no effect on the outputs.
- R10: Tuning words at and above 2^31 wrap correctly: 0x8000_0000 toggles `sq_out` every cycle, and 0xFFFF_FFFF steps the phase backward by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| upd | input | 1 | Update strobe; captures both words |
| ftw_in | input | 32 | Frequency tuning word |
| pofs_in | input | 5 | Phase offset word, bit 4 = 180° |
| pwr_dn | input | 1 | Power-down: hold phase, zero outputs |
| phase_addr | output | 12 | Truncated offset phase for the amplitude stage |
| sq_out | output | 1 | Registered MSB of the offset phase |

## Verification
A small tuning word tells the accumulation step apart from truncation. Each single offset bit in turn, and then all five bits together, separates the bit weights. Strobes on three consecutive cycles with different words expose any update that is lost or reordered. The offset and frequency paths are also compared on the exact cycle each one matures, which shows whether the two latencies are distinct. A tuning word of exactly half scale and one of all ones test modular wrap. Power-down in mid-run shows whether the phase was held. A reset with updates still pending shows whether those updates were dropped.

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
  parameter int FTW_W     = 32,
  parameter int POFS_W    = 5,
  parameter int ADDR_W    = 12,
  parameter int FREQ_LAT  = 18,
  parameter int PHASE_LAT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [FTW_W-1:0]  ftw_in,
  input  logic [POFS_W-1:0] pofs_in,
  input  logic              pwr_dn,
  output logic [ADDR_W-1:0] phase_addr,
  output logic              sq_out
);
  localparam int FDEPTH = FREQ_LAT - 2;
  localparam int PDEPTH = PHASE_LAT - 1;

  logic [FDEPTH-1:0] f_v;
  logic [FTW_W-1:0]  f_w [FDEPTH];
  logic [PDEPTH-1:0] p_v;
  logic [POFS_W-1:0] p_w [PDEPTH];

  logic [FTW_W-1:0]  ftw_act;
  logic [POFS_W-1:0] pofs_act;
  logic [FTW_W-1:0]  acc;
  logic [ADDR_W-1:0] ofs_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_v <= '0;
      p_v <= '0;
    end else begin
      f_v <= {f_v[FDEPTH-2:0], upd};
      p_v <= {p_v[PDEPTH-2:0], upd};
    end
  end

  always_ff @(posedge clk) begin
    f_w[0] <= ftw_in;
    p_w[0] <= pofs_in;
  end

  for (genvar i = 1; i < FDEPTH; i++) begin : g_fstage
    always_ff @(posedge clk) f_w[i] <= f_w[i-1];
  end

  for (genvar i = 1; i < PDEPTH; i++) begin : g_pstage
    always_ff @(posedge clk) p_w[i] <= p_w[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_act  <= '0;
      pofs_act <= '0;
    end else begin
      if (f_v[FDEPTH-1]) ftw_act  <= f_w[FDEPTH-1];
      if (p_v[PDEPTH-1]) pofs_act <= p_w[PDEPTH-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (!pwr_dn) acc <= acc + ftw_act;
  end

  assign ofs_top = acc[FTW_W-1 -: ADDR_W] + {pofs_act, {(ADDR_W-POFS_W){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || pwr_dn) begin
      phase_addr <= '0;
      sq_out     <= 1'b0;
    end else begin
      phase_addr <= ofs_top;
      sq_out     <= ofs_top[ADDR_W-1];
    end
  end

  // R7
  rst_clear_chk: assert property (@(posedge clk) rst |=> (phase_addr == '0 && !sq_out && acc == '0));

  // R6
  pd_zero_chk: assert property (@(posedge clk) disable iff (rst) pwr_dn |=> (phase_addr == '0 && !sq_out));

  // R6
  pd_hold_chk: assert property (@(posedge clk) disable iff (rst) pwr_dn |=> acc == $past(acc));

  // R3
  ftw_stable_chk: assert property (@(posedge clk) disable iff (rst) !f_v[FDEPTH-1] |=> $stable(ftw_act));

  // R4
  pofs_stable_chk: assert property (@(posedge clk) disable iff (rst) !p_v[PDEPTH-1] |=> $stable(pofs_act));

  // R8
  sq_msb_chk: assert property (@(posedge clk) disable iff (rst) sq_out == phase_addr[ADDR_W-1]);
endmodule

// File: tb/test_dds_phase_core.sv
`timescale 1ns/1ps
module test_dds_phase_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd = 1'b0;
  logic [31:0] ftw_in = '0;
  logic [4:0]  pofs_in = '0;
  logic        pwr_dn = 1'b0;
  logic [11:0] phase_addr;
  logic        sq_out;

  dds_phase_core i_dds_phase_core (
    .clk(clk), .rst(rst), .upd(upd), .ftw_in(ftw_in), .pofs_in(pofs_in),
    .pwr_dn(pwr_dn), .phase_addr(phase_addr), .sq_out(sq_out)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  string tag = "R7";

  logic [31:0] m_acc = '0;
  logic [31:0] m_ftw = '0;
  logic [4:0]  m_pofs = '0;
  logic [11:0] m_out = '0;
  int          fdue[$];
  logic [31:0] fw[$];
  int          pdue[$];
  logic [4:0]  pw[$];

  // Behavioural reference: latencies counted from the strobe edge.
  always @(posedge clk) begin
    logic [31:0] ph;
    cyc++;
    if (rst) begin
      m_acc = '0; m_ftw = '0; m_pofs = '0; m_out = '0;
      fdue.delete(); fw.delete(); pdue.delete(); pw.delete();
    end else begin
      ph = m_acc + {m_pofs, 27'd0};
      m_out = pwr_dn ? 12'd0 : ph[31:20];
      if (!pwr_dn) m_acc = m_acc + m_ftw;
      while (fdue.size() > 0 && fdue[0] == cyc) begin
        m_ftw = fw.pop_front(); void'(fdue.pop_front());
      end
      while (pdue.size() > 0 && pdue[0] == cyc) begin
        m_pofs = pw.pop_front(); void'(pdue.pop_front());
      end
      if (upd) begin
        fdue.push_back(cyc + 16); fw.push_back(ftw_in);
        pdue.push_back(cyc + 12); pw.push_back(pofs_in);
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      checks++;
      if (phase_addr !== m_out || sq_out !== m_out[11]) begin
        fails++;
        $display("FAIL %s cycle %0d: phase_addr=%h sq_out=%b expected %h %b",
                 tag, cyc, phase_addr, sq_out, m_out, m_out[11]);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] f, input logic [4:0] p);
    ftw_in = f; pofs_in = p; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tag = "R7 reset state";
    run(6);
    rst = 1'b0;
    run(4);
    tag = "R1 R3 frequency latency";
    load(32'h0100_0000, 5'd0);
    run(40);
    tag = "R2 R4 offset bits";
    for (int b = 0; b < 5; b++) begin
      load(32'h0100_0000, 5'(1 << b));
      run(20);
    end
    load(32'h0100_0000, 5'd31);
    run(20);
    tag = "R5 back-to-back updates";
    ftw_in = 32'h0030_0000; pofs_in = 5'd3; upd = 1'b1;
    @(negedge clk);
    ftw_in = 32'h0500_0000; pofs_in = 5'd9;
    @(negedge clk);
    ftw_in = 32'h0007_0000; pofs_in = 5'd20;
    @(negedge clk);
    upd = 1'b0;
    run(30);
    tag = "R9 inputs ignored without strobe";
    for (int k = 0; k < 20; k++) begin
      ftw_in = 32'hDEAD_0000 + 32'(k); pofs_in = 5'(k);
      @(negedge clk);
    end
    tag = "R6 power-down";
    pwr_dn = 1'b1;
    run(10);
    pwr_dn = 1'b0;
    run(20);
    tag = "R10 R8 half-scale word";
    load(32'h8000_0000, 5'd0);
    run(30);
    tag = "R10 all-ones word";
    load(32'hFFFF_FFFF, 5'd7);
    run(30);
    tag = "R7 reset drops pending updates";
    load(32'h1234_5678, 5'd17);
    run(3);
    rst = 1'b1;
    run(5);
    rst = 1'b0;
    run(30);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule